// File: doc/BRIEF.md
# Clause 45 MDIO Management Slave

This block is the slave end of a two-wire management link of the Clause 45 kind. A master supplies the management clock and sends 64-bit frames on a shared data line. The slave looks for a run of at least 32 ones, then decodes the rest of the frame: a start code, an operation code, a port address and a device type. It acts only on frames whose port address and device type equal the values strapped on its pins. Register access is indirect. An address frame loads an internal pointer. Later write or read frames then use that pointer. One read variant steps the pointer by one after the read, so a run of registers can be read without repeated address frames.

The local register space sits behind a simple bus in the management clock domain. It has a pointer output, a one-cycle write strobe with write data, and a one-cycle read strobe. The register file must answer the read strobe with data in the same cycle. For reads the slave turns the line around: it drives a zero in the second turnaround bit and then the sixteen data bits, most significant first. All driven values change on the falling edge of the management clock. The master samples on the rising edge.

Top module: `mdio_c45_slave`

## Requirements
- R1: While reset is low at a rising clock edge, the read strobe, the write strobe and the output enable go low, and the pointer goes to 0.
- R2: Field order after the preamble is start (2 bits), opcode (2 bits), port address (5 bits, MSB first), device type (5 bits, MSB first), turnaround (2 bits) and a 16-bit data field. An accepted frame with opcode 00 loads the pointer from the data field at the edge that samples the last data bit.
- R3: An accepted frame with opcode 01 gives exactly one write strobe cycle, in the cycle after the last data bit. In that cycle the write data equals the data field and the pointer is unchanged.
- R4: On an accepted read (opcode 10 or 11), the read strobe is high for the single cycle that follows the last device-type bit. The register data present in that cycle is returned. The output enable is high for the second turnaround bit (value 0) and the 16 data bits (MSB first), 17 bit times in total. The output enable and the driven data change only on falling clock edges.
- R5: Opcode 10 returns the register at the current pointer and then adds one to the pointer, wrapping from 0xFFFF to 0x0000.
- R6: Opcode 11 returns the register at the pointer and leaves the pointer unchanged.
- R7: A frame whose start code is 01 is ignored. No strobe fires, the line is not driven, and the pointer is not changed.
- R8: A frame whose port address or device type differs from the strapped value is ignored in the same way as in R7.
- R9: A frame is accepted only after at least 32 consecutive ones precede its start code. With 31 ones the frame is ignored. With 32 or more it is accepted.
- R10: The turnaround bits of incoming address and write frames do not affect the result. All four values give the same behaviour.
- R11: When the strapped device type is 0, no frame is accepted, even one whose device type field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the master |
| rst_n | input | 1 | Synchronous active-low reset |
| mdio_i | input | 1 | Data line as seen at the pin |
| mdio_o | output | 1 | Data driven by the slave (updated on falling edge) |
| mdio_oe | output | 1 | Drive enable for the data line (updated on falling edge) |
| strap_port | input | 5 | Strapped port address |
| strap_dev | input | 5 | Strapped device type |
| reg_addr | output | 16 | Register pointer presented to the register file |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Read data, valid in the read strobe cycle |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Write data, valid with the write strobe |

## Verification
On an incrementing read, two things happen on the same rising edge: the read data is captured and the pointer is stepped. Data from the new pointer in place of the old one would be the typical fault. The bench sets the pointer to zero and issues 37 incrementing reads back to back, plus one across the 0xFFFF wrap. The register file model returns an arithmetic function of the pointer. Each returned word is compared with the function of the pointer before the step, and the pointer seen after the frame is compared with that value plus one.

// File: rtl/mdio_c45_pkg.sv
// Shared types for the Clause 45 management slave.
// Assumes: opcode values are fixed by the line protocol.
package mdio_c45_pkg;

    typedef enum logic [1:0] {
        OP_SET_ADDR = 2'b00,
        OP_WRITE    = 2'b01,
        OP_READ_INC = 2'b10,
        OP_READ     = 2'b11
    } mdio_op_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_HEADER,
        RX_TURN,
        RX_DATA
    } rx_state_e;

endpackage

// File: rtl/mdio_pre_det.sv
// Preamble detector: counts consecutive ones on the sampled line and
// reports when at least PRE_LEN of them have been seen.
// Assumes: the line is sampled on the rising edge of the management clock.
module mdio_pre_det #(
    parameter int PRE_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic armed
);
    localparam int CW = $clog2(PRE_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(PRE_LEN);

    logic [CW-1:0] ones_q;

    // Saturating run-length count of ones; any zero clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (!din) begin
            ones_q <= '0;
        end else if (ones_q != FULL) begin
            ones_q <= ones_q + 1'b1;
        end
    end

    assign armed = (ones_q == FULL);
endmodule

// File: rtl/mdio_frame_rx.sv
// Frame receiver: steps through start, opcode, port, device, turnaround and
// data fields. It filters frames on start code and straps, and emits
// events for the register port and the line driver.
// Assumes: fields arrive MSB first; a frame is started by a zero that
// follows an armed preamble.
module mdio_frame_rx
    import mdio_c45_pkg::*;
#(
    parameter int PA_W   = 5,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      din,
    input  logic                      armed,
    input  logic [PA_W-1:0]           strap_port,
    input  logic [PA_W-1:0]           strap_dev,
    output logic                      rd_req,
    output logic                      rd_incr,
    output logic                      wr_evt,
    output logic                      adr_evt,
    output logic [DATA_W-1:0]         word,
    output logic                      drv_turn,
    output logic                      drv_data,
    output logic [$clog2(DATA_W)-1:0] bit_idx
);
    localparam int HDR_BITS = 3 + 2 * PA_W;
    localparam int CNT_W    = $clog2(HDR_BITS + DATA_W);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(1);
    localparam logic [IDX_W-1:0] MSB_IDX   = IDX_W'(DATA_W - 1);

    rx_state_e           state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [HDR_BITS-2:0] hdr_q;
    logic [DATA_W-2:0]   dat_q;
    mdio_op_e            op_q;

    logic [HDR_BITS-1:0] hdr_next;
    logic [DATA_W-1:0]   dat_next;
    mdio_op_e            op_in;
    logic [PA_W-1:0]     port_in;
    logic [PA_W-1:0]     dev_in;
    logic                hdr_ok;
    logic                is_read;
    logic                data_done;

    // Field extraction from the header shift register plus the current bit.
    always_comb begin
        hdr_next = {hdr_q, din};
        dat_next = {dat_q, din};
        op_in    = mdio_op_e'(hdr_next[2*PA_W+1 -: 2]);
        port_in  = hdr_next[2*PA_W-1 -: PA_W];
        dev_in   = hdr_next[PA_W-1:0];
        hdr_ok   = !hdr_next[HDR_BITS-1]
                   && (port_in == strap_port)
                   && (dev_in == strap_dev)
                   && (strap_dev != '0);
    end

    // Frame sequencer with a shared bit counter for every field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
            cnt_q   <= '0;
            hdr_q   <= '0;
            dat_q   <= '0;
            op_q    <= OP_SET_ADDR;
        end else begin
            case (state_q)
                RX_HUNT: begin
                    if (armed && !din) begin
                        state_q <= RX_HEADER;
                        cnt_q   <= '0;
                    end
                end
                RX_HEADER: begin
                    hdr_q <= hdr_next[HDR_BITS-2:0];
                    if (cnt_q == '0 && din) begin
                        state_q <= RX_HUNT;
                    end else if (cnt_q == HDR_LAST) begin
                        cnt_q <= '0;
                        if (hdr_ok) begin
                            state_q <= RX_TURN;
                            op_q    <= op_in;
                        end else begin
                            state_q <= RX_HUNT;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_TURN: begin
                    if (cnt_q == TURN_LAST) begin
                        state_q <= RX_DATA;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    dat_q <= dat_next[DATA_W-2:0];
                    if (cnt_q == DATA_LAST) begin
                        state_q <= RX_HUNT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Events and driver controls decoded from the sequencer state.
    always_comb begin
        is_read   = op_q[1];
        data_done = (state_q == RX_DATA) && (cnt_q == DATA_LAST);
        rd_req    = (state_q == RX_TURN) && (cnt_q == '0) && is_read;
        rd_incr   = (op_q == OP_READ_INC);
        wr_evt    = data_done && (op_q == OP_WRITE);
        adr_evt   = data_done && (op_q == OP_SET_ADDR);
        word      = dat_next;
        drv_turn  = (state_q == RX_TURN) && (cnt_q == TURN_LAST) && is_read;
        drv_data  = (state_q == RX_DATA) && is_read;
        bit_idx   = MSB_IDX - cnt_q[IDX_W-1:0];
    end
endmodule

// File: rtl/mdio_reg_port.sv
// Register port: holds the address pointer and drives the synchronous
// register bus. It captures read data and steps the pointer after an
// incrementing read.
// Assumes: read data is valid in the same cycle as the read request.
module mdio_reg_port #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              rd_incr,
    input  logic              wr_evt,
    input  logic              adr_evt,
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ptr,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);
    // Pointer, write strobe and read capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            wr_stb  <= 1'b0;
            wdata   <= '0;
            rd_word <= '0;
        end else begin
            wr_stb <= wr_evt;
            if (wr_evt) begin
                wdata <= word;
            end
            if (rd_req) begin
                rd_word <= rdata;
            end
            if (adr_evt) begin
                ptr <= word;
            end else if (rd_req && rd_incr) begin
                ptr <= ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_tx_drv.sv
// Line driver: updates the output enable and the output bit on the
// falling edge, so that the master samples a settled value on the next
// rising edge.
// Assumes: controls from the receiver are stable across the falling edge.
module mdio_tx_drv #(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      drv_turn,
    input  logic                      drv_data,
    input  logic [$clog2(DATA_W)-1:0] bit_idx,
    input  logic [DATA_W-1:0]         rd_word,
    output logic                      oe,
    output logic                      dout
);
    // Falling-edge output register for the shared line.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            oe   <= 1'b0;
            dout <= 1'b0;
        end else begin
            oe   <= drv_turn | drv_data;
            dout <= drv_data ? rd_word[bit_idx] : 1'b0;
        end
    end
endmodule

// File: rtl/mdio_c45_slave.sv
// Top of the Clause 45 management slave: preamble detector, frame
// receiver, register port and line driver.
// Assumes: everything runs on the external management clock; the pad
// combines mdio_o and mdio_oe into the bidirectional pin.
module mdio_c45_slave #(
    parameter int PRE_LEN = 32,
    parameter int PA_W    = 5,
    parameter int DATA_W  = 16
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic [PA_W-1:0]   strap_port,
    input  logic [PA_W-1:0]   strap_dev,
    output logic [DATA_W-1:0] reg_addr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata
);
    localparam int IDX_W = $clog2(DATA_W);

    logic              armed;
    logic              rd_req;
    logic              rd_incr;
    logic              wr_evt;
    logic              adr_evt;
    logic [DATA_W-1:0] word;
    logic              drv_turn;
    logic              drv_data;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] rd_word;

    mdio_pre_det #(.PRE_LEN(PRE_LEN)) u_pre (
        .clk   (mdc),
        .rst_n (rst_n),
        .din   (mdio_i),
        .armed (armed)
    );

    mdio_frame_rx #(.PA_W(PA_W), .DATA_W(DATA_W)) u_rx (
        .clk        (mdc),
        .rst_n      (rst_n),
        .din        (mdio_i),
        .armed      (armed),
        .strap_port (strap_port),
        .strap_dev  (strap_dev),
        .rd_req     (rd_req),
        .rd_incr    (rd_incr),
        .wr_evt     (wr_evt),
        .adr_evt    (adr_evt),
        .word       (word),
        .drv_turn   (drv_turn),
        .drv_data   (drv_data),
        .bit_idx    (bit_idx)
    );

    mdio_reg_port #(.DATA_W(DATA_W)) u_port (
        .clk     (mdc),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_incr (rd_incr),
        .wr_evt  (wr_evt),
        .adr_evt (adr_evt),
        .word    (word),
        .rdata   (reg_rdata),
        .ptr     (reg_addr),
        .wr_stb  (reg_wr),
        .wdata   (reg_wdata),
        .rd_word (rd_word)
    );

    mdio_tx_drv #(.DATA_W(DATA_W)) u_tx (
        .clk      (mdc),
        .rst_n    (rst_n),
        .drv_turn (drv_turn),
        .drv_data (drv_data),
        .bit_idx  (bit_idx),
        .rd_word  (rd_word),
        .oe       (mdio_oe),
        .dout     (mdio_o)
    );

    assign reg_rd = rd_req;
endmodule

// File: rtl/mdio_c45_slave_chk.sv
// Protocol checker for the management slave, bound to the top module.
// Assumes: observation on rising edges of the management clock.
module mdio_c45_slave_chk #(
    parameter int DATA_W = 16
) (
    input logic              mdc,
    input logic              rst_n,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic [DATA_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              reg_wr
);
    localparam int RUN_W = $clog2(DATA_W + 3);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DATA_W + 1);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(DATA_W + 2);

    logic [RUN_W-1:0] oe_run_q;

    // Length of the current output-enable burst, saturating.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            oe_run_q <= '0;
        end else if (!mdio_oe) begin
            oe_run_q <= '0;
        end else if (oe_run_q != RUN_SAT) begin
            oe_run_q <= oe_run_q + 1'b1;
        end
    end

    // R4: a drive burst never exceeds turnaround plus data width.
    always_comb begin
        if (rst_n) begin
            a_r4_oe_window: assert (oe_run_q <= RUN_MAX);
        end
    end

    // R1: reset leaves strobes low and the pointer at zero.
    a_r1_reset_quiet: assert property (@(posedge mdc)
        !rst_n |=> (!reg_wr && !reg_rd && reg_addr == '0));

    // R3: write strobe lasts a single cycle.
    a_r3_wr_single: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R3: a write does not move the pointer.
    a_r3_wr_addr_stable: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_wr |-> $stable(reg_addr));

    // R3/R4: read and write strobes never coincide.
    a_r3_wr_rd_excl: assert property (@(posedge mdc) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd}));

    // R4: read strobe lasts a single cycle.
    a_r4_rd_single: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R4: the cycle after the read strobe the line is driven low.
    a_r4_oe_after_rd: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_rd |=> (mdio_oe && !mdio_o));

    // R4: driving only starts after a read strobe.
    a_r4_oe_follows_rd: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(reg_rd));
endmodule

bind mdio_c45_slave mdio_c45_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .mdc      (mdc),
    .rst_n    (rst_n),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .reg_addr (reg_addr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr)
);

// File: tb/mdio_c45_slave_bench.sv
// Bench for the management slave: the master drives on falling edges,
// and a register file model answers with an arithmetic function of the
// pointer.
module mdio_c45_slave_bench;
    localparam int CLK_PERIOD = 400;
    localparam logic [4:0] MY_PORT = 5'h0B;
    localparam logic [4:0] MY_DEV  = 5'd3;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_bit = 1'b1;
    logic [4:0]  strap_port = MY_PORT;
    logic [4:0]  strap_dev = MY_DEV;
    logic        mdio_i, mdio_o, mdio_oe, reg_rd, reg_wr;
    logic [15:0] reg_addr, reg_rdata, reg_wdata;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] ptr = 16'h0000;

    logic        rec_oe   [0:33];
    logic        rec_o    [0:33];
    logic        late_oe  [0:33];
    logic        late_o   [0:33];
    logic        rec_wr   [0:33];
    logic        rec_rd   [0:33];
    logic [15:0] rec_addr [0:33];
    logic [15:0] rec_wd   [0:33];

    function automatic logic [15:0] model(input logic [15:0] a);
        return (a * 16'h9E37) ^ 16'h5A5A;
    endfunction

    assign mdio_i    = mdio_oe ? mdio_o : master_bit;
    assign reg_rdata = model(reg_addr);

    always #(CLK_PERIOD / 2) mdc = ~mdc;

    mdio_c45_slave u_mdio_c45_slave (
        .mdc        (mdc),
        .rst_n      (rst_n),
        .mdio_i     (mdio_i),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .strap_port (strap_port),
        .strap_dev  (strap_dev),
        .reg_addr   (reg_addr),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bit time: drive after the falling edge, sample before and after the rising edge.
    task automatic slot(input logic b, input int j);
        @(negedge mdc);
        master_bit = b;
        #(CLK_PERIOD / 4);
        if (j >= 0) begin
            rec_oe[j] = mdio_oe; rec_o[j] = mdio_o; rec_wr[j] = reg_wr;
            rec_rd[j] = reg_rd;  rec_addr[j] = reg_addr; rec_wd[j] = reg_wdata;
        end
        #(CLK_PERIOD / 2);
        if (j >= 0) begin
            late_oe[j] = mdio_oe; late_o[j] = mdio_o;
        end
    endtask

    task automatic frame(input int npre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] pa, input logic [4:0] dv,
                         input logic [1:0] ta, input logic [15:0] d);
        logic [31:0] v;
        v = {st, op, pa, dv, ta, d};
        slot(1'b0, -1);
        for (int i = 0; i < npre; i++) slot(1'b1, -1);
        for (int j = 0; j < 32; j++) slot(v[31-j], j);
        slot(1'b1, 32);
        slot(1'b1, 33);
    endtask

    function automatic int count_oe();
        int c = 0;
        for (int j = 0; j < 34; j++) c += int'(rec_oe[j]);
        return c;
    endfunction
    function automatic int count_wr();
        int c = 0;
        for (int j = 0; j < 34; j++) c += int'(rec_wr[j]);
        return c;
    endfunction
    function automatic int count_rd();
        int c = 0;
        for (int j = 0; j < 34; j++) c += int'(rec_rd[j]);
        return c;
    endfunction

    // Frame expected to have no effect at all.
    task automatic expect_quiet(input string req);
        chk({req, " no drive"}, count_oe(), 0);
        chk({req, " no write"}, count_wr(), 0);
        chk({req, " no read"}, count_rd(), 0);
        chk({req, " pointer kept"}, {16'h0, rec_addr[33]}, {16'h0, ptr});
    endtask

    task automatic expect_read(input string req, input logic [15:0] nxt);
        logic [15:0] w;
        int skew;
        w = '0;
        skew = 0;
        for (int k = 0; k < 16; k++) w[15-k] = rec_o[16+k];
        for (int j = 0; j < 34; j++)
            if (rec_oe[j] !== late_oe[j] || (rec_oe[j] && rec_o[j] !== late_o[j])) skew++;
        chk("R4 one read strobe", count_rd(), 1);
        chk("R4 strobe after device field", {31'h0, rec_rd[14]}, 1);
        chk("R4 drive length 17", count_oe(), 17);
        chk("R4 turnaround driven low", {30'h0, rec_oe[15], rec_o[15]}, 2'b10);
        chk("R4 released after data", {31'h0, rec_oe[32]}, 0);
        chk("R4 change only on falling edge", skew, 0);
        chk({req, " read data"}, {16'h0, w}, {16'h0, model(ptr)});
        chk({req, " pointer after read"}, {16'h0, rec_addr[33]}, {16'h0, nxt});
        ptr = nxt;
    endtask

    task automatic do_addr(input string req, input logic [15:0] a, input logic [1:0] ta);
        frame(32, 2'b00, 2'b00, MY_PORT, MY_DEV, ta, a);
        chk({req, " pointer held before last bit"}, {16'h0, rec_addr[31]}, {16'h0, ptr});
        chk({req, " pointer loaded"}, {16'h0, rec_addr[33]}, {16'h0, a});
        chk({req, " address frame silent"}, count_oe() + count_wr() + count_rd(), 0);
        ptr = a;
    endtask

    initial begin
        repeat (5) @(posedge mdc);
        @(negedge mdc);
        #(CLK_PERIOD / 4);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 oe after reset", {31'h0, mdio_oe}, 0);
        chk("R1 strobes after reset", {30'h0, reg_wr, reg_rd}, 0);
        chk("R1 pointer after reset", {16'h0, reg_addr}, 0);

        // R2 address load, then R5 incrementing sweep over 0x0000..0x0024
        do_addr("R2", 16'h0000, 2'b11);
        for (int i = 0; i <= 16'h24; i++) begin
            frame(32, 2'b00, 2'b10, MY_PORT, MY_DEV, 2'b11, 16'hFFFF);
            expect_read("R5", ptr + 16'h1);
        end
        // R6 plain read keeps the pointer
        for (int i = 0; i < 3; i++) begin
            frame(32, 2'b00, 2'b11, MY_PORT, MY_DEV, 2'b11, 16'hFFFF);
            expect_read("R6", ptr);
        end

        // R3 writes with every turnaround value (R10)
        for (int t = 0; t < 4; t++) begin
            logic [15:0] d;
            d = 16'hC3A0 + 16'(t * 7);
            do_addr("R10", 16'h0010 + 16'(t), 2'(t));
            frame(32, 2'b00, 2'b01, MY_PORT, MY_DEV, 2'(t), d);
            chk("R3 one write strobe", count_wr(), 1);
            chk("R3 strobe after last bit", {31'h0, rec_wr[32]}, 1);
            chk("R3 write data", {16'h0, rec_wd[32]}, {16'h0, d});
            chk("R3 write address", {16'h0, rec_addr[32]}, {16'h0, ptr});
            chk("R3 pointer unchanged", {16'h0, rec_addr[33]}, {16'h0, ptr});
            chk("R10 no drive on write", count_oe(), 0);
        end

        // R5 wrap of the pointer
        do_addr("R5", 16'hFFFF, 2'b00);
        frame(32, 2'b00, 2'b10, MY_PORT, MY_DEV, 2'b11, 16'hFFFF);
        expect_read("R5 wrap", 16'h0000);

        // R7 start code 01 ignored
        do_addr("R7", 16'h0042, 2'b10);
        frame(32, 2'b01, 2'b01, MY_PORT, MY_DEV, 2'b00, 16'h1234);
        expect_quiet("R7 write");
        frame(32, 2'b01, 2'b00, MY_PORT, MY_DEV, 2'b00, 16'h1234);
        expect_quiet("R7 address");
        frame(32, 2'b01, 2'b11, MY_PORT, MY_DEV, 2'b00, 16'h1234);
        expect_quiet("R7 read");

        // R8 port sweep and device sweep
        for (int p = 0; p < 32; p++) begin
            frame(32, 2'b00, 2'b00, 5'(p), MY_DEV, 2'b00, 16'h0200 + 16'(p));
            if (5'(p) == MY_PORT) begin
                chk("R8 matching port loads", {16'h0, rec_addr[33]}, 32'h0200 + p);
                ptr = 16'h0200 + 16'(p);
            end else begin
                expect_quiet("R8 port mismatch");
            end
        end
        for (int v = 0; v < 32; v++) begin
            frame(32, 2'b00, 2'b00, MY_PORT, 5'(v), 2'b00, 16'h0300 + 16'(v));
            if (5'(v) == MY_DEV) begin
                chk("R8 matching device loads", {16'h0, rec_addr[33]}, 32'h0300 + v);
                ptr = 16'h0300 + 16'(v);
            end else begin
                expect_quiet("R8 device mismatch");
            end
        end

        // R9 preamble length
        frame(31, 2'b00, 2'b00, MY_PORT, MY_DEV, 2'b00, 16'h0ABC);
        expect_quiet("R9 31 ones");
        frame(32, 2'b00, 2'b00, MY_PORT, MY_DEV, 2'b00, 16'h0ABC);
        chk("R9 32 ones accepted", {16'h0, rec_addr[33]}, 32'h0ABC);
        ptr = 16'h0ABC;
        frame(40, 2'b00, 2'b00, MY_PORT, MY_DEV, 2'b00, 16'h0BCD);
        chk("R9 40 ones accepted", {16'h0, rec_addr[33]}, 32'h0BCD);
        ptr = 16'h0BCD;

        // R11 device strap of zero never matches
        strap_dev = 5'd0;
        frame(32, 2'b00, 2'b00, MY_PORT, 5'd0, 2'b00, 16'h0777);
        expect_quiet("R11 zero device");
        frame(32, 2'b00, 2'b11, MY_PORT, 5'd0, 2'b11, 16'h1234);
        expect_quiet("R11 zero device read");
        strap_dev = MY_DEV;
        frame(32, 2'b00, 2'b11, MY_PORT, MY_DEV, 2'b11, 16'hFFFF);
        expect_read("R6 after strap restore", ptr);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule